// File: doc/BRIEF.md
# Linked Buffer Descriptor Walker

This block serves a single channel, in either the transmit or the receive direction, whose traffic lives in a shared byte-wide external memory as a chain of self-linked buffers. Software places the first buffer's address on the start inputs and pulses `start`. From then on the walker needs no help from software. It reads each buffer's header, which holds a forward link, a capacity, a byte count and a status byte. It then moves the payload. For a data buffer, payload bytes are streamed out to the transmit side or written in from the receive side. For a command buffer, a new mode and rate byte is loaded into the channel's configuration registers.

When a buffer is finished, the walker marks it done in memory and follows the forward link to the next buffer. A status write-back raises an interrupt strobe for as long as that write is in flight. A forward link that is zero, or whose upper twelve bits are all ones, is refused. In that case the current buffer's status records the error and the channel falls idle. Memory traffic goes through a single request/grant port with one access in flight at a time.

Top module: `bdw_walker`

## Requirements
- R1: After reset the channel is idle: `active`, `mem_req`, `intr`, `tx_valid` and `rx_ready` are 0, `mode_flags` is 0 and `fill_mask` is 8'hFF.
- R2: Header layout relative to the buffer base is as follows. Offsets 0–1 hold the forward link, 2–3 the capacity and 4–5 the byte count, each field most significant byte first. Offset 6 is not read. Offset 7 holds the status byte, and the payload starts at offset 8.
- R3: A `start` pulse with a start address of 16'h0000 or 16'hFFFx is ignored: `active` stays 0 and no memory request is made.
- R4: In the transmit direction (`rx_dir`=0), a data buffer delivers exactly byte-count payload bytes in address order on `tx_byte`. Each byte is held with `tx_valid` high until a cycle with `tx_ready` high.
- R5: When a buffer is finished, its status byte is rewritten with bit 0 (done) set, and the walker goes straight on to the next buffer without any external action. In transmit, the byte stream therefore continues with the next buffer's first payload byte.
- R6: Status bit 7 marks a command buffer. Its payload byte at offset 8 sets `mode_flags` from bits [3:0] (bit 0 framed mode, bit 1 signalling mode, bit 2 loopback, bit 3 inversion). The byte at offset 9 sets `fill_mask`. Both are applied together, and no payload is streamed.
- R7: A forward link of 16'h0000 or 16'hFFFx makes the status write-back also set bit 2 (bad link). After that write, `active` drops and no further memory request is made.
- R8: `intr` is high exactly in the cycles in which a status write (write request to base+7) is pending.
- R9: In the receive direction (`rx_dir`=1), accepted bytes are written in order from base+8. A byte flagged `rx_last` closes the buffer. The byte count is then written MSB at base+4 and LSB at base+5, and status is written with bits 0 and 1 (frame end) set.
- R10: In receive, when the number of stored bytes reaches the capacity, the buffer is closed with byte count equal to the capacity and status bit 1 clear. The walker then moves to the next buffer.
- R11: A memory request keeps its address, direction and write data stable until granted. Read data is taken in the grant cycle, and only addresses named in R2, R6 and R9 are touched.
- R12: A `start` pulse while the channel is active has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin walking a chain |
| start_addr | input | 16 | Address of the first buffer |
| rx_dir | input | 1 | 1 = receive channel, 0 = transmit channel |
| active | output | 1 | Channel is walking a chain |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | One-cycle grant, completes the access |
| mem_rdata | input | 8 | Read data, valid with grant |
| intr | output | 1 | Status write strobe |
| tx_byte | output | 8 | Outgoing payload byte |
| tx_valid | output | 1 | `tx_byte` holds a byte |
| tx_ready | input | 1 | Consumer takes the byte |
| rx_byte | input | 8 | Incoming payload byte |
| rx_last | input | 1 | Byte closes a frame, abort or sync loss |
| rx_valid | input | 1 | `rx_byte` is offered |
| rx_ready | output | 1 | Walker accepts a byte this cycle |
| mode_flags | output | 4 | Channel mode from the last command buffer |
| fill_mask | output | 8 | Rate mask from the last command buffer |

## Verification
Two events can land in the same cycle. One is the consumer's acceptance of the last held transmit byte. The other is the grant for the status write-back or for the next header read, because the walker leaves a buffer as soon as its last byte is fetched, even if that byte is not yet consumed. The bench provokes this by toggling `tx_ready` while the memory model varies its grant latency over a two-buffer chain with a command buffer in the middle. It judges the outcome by the exact byte order at the transmit port, the status values written back, and the total number of grants. On the receive side, a buffer reaching capacity and a byte arriving on the next cycle are checked the same way: by payload placement and by the byte counts written back.

// File: rtl/bdw_pkg.sv
// Shared constants and state type for the buffer descriptor walker.
// Assumes a header of eight bytes ahead of the payload in each buffer.
package bdw_pkg;
    // Walker states
    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_CMD, S_TXD, S_RXD, S_LEN, S_STS
    } walk_st_e;

    localparam int OFS_LEN_HI  = 4;
    localparam int OFS_STATUS  = 7;
    localparam int OFS_PAYLOAD = 8;

    // Status bit positions
    localparam int ST_DONE = 0;
    localparam int ST_FEND = 1;
    localparam int ST_BADL = 2;
    localparam int ST_CMD  = 7;
endpackage

// File: rtl/bdw_link_chk.sv
// Link validity test: an address is usable unless it is zero or its
// upper bits are all ones (top sixteen addresses). Purely combinational.
module bdw_link_chk #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    output logic          ok
);
    localparam int HI_W = AW - 4;

    // Refuse zero and the all-ones top block
    always_comb begin
        ok = (addr != '0) && (addr[AW-1:4] != {HI_W{1'b1}});
    end
endmodule

// File: rtl/bdw_cfg_regs.sv
// Channel configuration held from the last command buffer.
// Assumes mode and rate are loaded together in one strobe.
module bdw_cfg_regs #(
    parameter int DW = 8,
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [MW-1:0] mode_in,
    input  logic [DW-1:0] fill_in,
    output logic [MW-1:0] mode_q,
    output logic [DW-1:0] fill_q
);
    // Reset to full rate, plain mode; load both fields atomically
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            fill_q <= '1;
        end else if (load) begin
            mode_q <= mode_in;
            fill_q <= fill_in;
        end
    end
endmodule

// File: rtl/bdw_walker.sv
// Walks a chain of linked buffers for one channel over a request/grant
// byte memory port. Reads headers, streams or stores payload, applies
// command buffers, writes status back and follows links. Assumes the
// memory grants each request exactly once, with read data valid on grant.
module bdw_walker
    import bdw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          rx_dir,
    output logic          active,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          intr,
    output logic [DW-1:0] tx_byte,
    output logic          tx_valid,
    input  logic          tx_ready,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_last,
    input  logic          rx_valid,
    output logic          rx_ready,
    output logic [MW-1:0] mode_flags,
    output logic [DW-1:0] fill_mask
);
    localparam int LW = 2 * DW;

    walk_st_e      st;
    logic [AW-1:0] base, nxt;
    logic [LW-1:0] bsize, blen, cnt;
    logic [DW-1:0] bstat, hold, wbuf;
    logic [2:0]    idx;
    logic          hold_v, wpend, wlast, fend, cmd_idx, dir_q;
    logic [MW-1:0] tmp_mode;
    logic [AW-1:0] ofs;
    logic          start_ok, nxt_ok, cfg_load;
    logic [DW-1:0] st_wb;
    logic [LW-1:0] cnt_inc;

    bdw_link_chk #(.AW(AW)) i_start_chk (.addr(start_addr), .ok(start_ok));
    bdw_link_chk #(.AW(AW)) i_next_chk  (.addr(nxt),        .ok(nxt_ok));

    bdw_cfg_regs #(.DW(DW), .MW(MW)) i_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .mode_in(tmp_mode), .fill_in(mem_rdata),
        .mode_q(mode_flags), .fill_q(fill_mask)
    );

    assign cnt_inc  = cnt + LW'(1);
    assign cfg_load = (st == S_CMD) && mem_gnt && cmd_idx;
    assign active   = (st != S_IDLE);
    assign intr     = (st == S_STS);
    assign rx_ready = (st == S_RXD) && !wpend;
    assign tx_byte  = hold;
    assign tx_valid = hold_v;
    assign mem_addr = base + ofs;

    // Status value written back when a buffer is closed
    always_comb begin
        st_wb          = bstat;
        st_wb[ST_DONE] = 1'b1;
        if (fend)    st_wb[ST_FEND] = 1'b1;
        if (!nxt_ok) st_wb[ST_BADL] = 1'b1;
    end

    // Memory request decode per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        ofs       = '0;
        unique case (st)
            S_HDR: begin
                mem_req = 1'b1;
                ofs     = AW'(idx);
            end
            S_CMD: begin
                mem_req = 1'b1;
                ofs     = AW'(OFS_PAYLOAD) + AW'(cmd_idx);
            end
            S_TXD: begin
                mem_req = !hold_v && (cnt != blen);
                ofs     = AW'(OFS_PAYLOAD) + AW'(cnt);
            end
            S_RXD: begin
                mem_req   = wpend;
                mem_we    = 1'b1;
                mem_wdata = wbuf;
                ofs       = AW'(OFS_PAYLOAD) + AW'(cnt);
            end
            S_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = idx[0] ? cnt[DW-1:0] : cnt[LW-1:DW];
                ofs       = AW'(OFS_LEN_HI) + AW'(idx[0]);
            end
            S_STS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = st_wb;
                ofs       = AW'(OFS_STATUS);
            end
            default: ;
        endcase
    end

    // Transmit holding register: loaded on payload grant, emptied on handoff
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            hold_v <= 1'b0;
        end else if (st == S_TXD && mem_gnt) begin
            hold   <= mem_rdata;
            hold_v <= 1'b1;
        end else if (hold_v && tx_ready) begin
            hold_v <= 1'b0;
        end
    end

    // Walk sequencer: header, payload, length, status, link
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            base     <= '0;
            nxt      <= '0;
            bsize    <= '0;
            blen     <= '0;
            bstat    <= '0;
            cnt      <= '0;
            idx      <= '0;
            wbuf     <= '0;
            wpend    <= 1'b0;
            wlast    <= 1'b0;
            fend     <= 1'b0;
            cmd_idx  <= 1'b0;
            dir_q    <= 1'b0;
            tmp_mode <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start && start_ok) begin
                    base  <= start_addr;
                    dir_q <= rx_dir;
                    idx   <= '0;
                    st    <= S_HDR;
                end
                S_HDR: if (mem_gnt) begin
                    idx <= (idx == 3'd5) ? 3'd7 : idx + 3'd1;
                    unique case (idx)
                        3'd0: nxt[AW-1:DW]  <= mem_rdata;
                        3'd1: nxt[DW-1:0]   <= mem_rdata;
                        3'd2: bsize[LW-1:DW] <= mem_rdata;
                        3'd3: bsize[DW-1:0]  <= mem_rdata;
                        3'd4: blen[LW-1:DW]  <= mem_rdata;
                        3'd5: blen[DW-1:0]   <= mem_rdata;
                        default: begin
                            bstat   <= mem_rdata;
                            cnt     <= '0;
                            fend    <= 1'b0;
                            wpend   <= 1'b0;
                            cmd_idx <= 1'b0;
                            idx     <= '0;
                            if (mem_rdata[ST_CMD])   st <= S_CMD;
                            else if (!dir_q)         st <= S_TXD;
                            else if (bsize == '0)    st <= S_LEN;
                            else                     st <= S_RXD;
                        end
                    endcase
                end
                S_CMD: if (mem_gnt) begin
                    if (!cmd_idx) begin
                        tmp_mode <= mem_rdata[MW-1:0];
                        cmd_idx  <= 1'b1;
                    end else begin
                        st <= S_STS;
                    end
                end
                S_TXD: begin
                    if (mem_gnt)            cnt <= cnt_inc;
                    else if (cnt == blen)   st  <= S_STS;
                end
                S_RXD: begin
                    if (rx_valid && !wpend) begin
                        wbuf  <= rx_byte;
                        wlast <= rx_last;
                        wpend <= 1'b1;
                    end
                    if (mem_gnt) begin
                        wpend <= 1'b0;
                        cnt   <= cnt_inc;
                        if (wlast || cnt_inc == bsize) begin
                            fend <= wlast;
                            idx  <= '0;
                            st   <= S_LEN;
                        end
                    end
                end
                S_LEN: if (mem_gnt) begin
                    if (idx[0]) st  <= S_STS;
                    else        idx <= 3'd1;
                end
                S_STS: if (mem_gnt) begin
                    idx <= '0;
                    if (nxt_ok) begin
                        base <= nxt;
                        st   <= S_HDR;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bdw_walker_chk.sv
// Protocol checker for the walker, attached by bind. Observes ports only.
module bdw_walker_chk #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int MW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic          rx_dir,
    input logic          active,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_gnt,
    input logic [DW-1:0] mem_rdata,
    input logic          intr,
    input logic [DW-1:0] tx_byte,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [DW-1:0] rx_byte,
    input logic          rx_last,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic [MW-1:0] mode_flags,
    input logic [DW-1:0] fill_mask
);
    // R11
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)
                               && $stable(mem_we) && $stable(mem_wdata));
    // R8
    intr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> mem_req && mem_we && (mem_addr[2:0] == 3'd7));
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req && !intr && !rx_ready);
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
    // R9
    rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && rx_valid |=> !rx_ready);
endmodule

bind bdw_walker bdw_walker_chk #(.AW(AW), .DW(DW), .MW(MW)) i_bdw_walker_chk (.*);

// File: tb/test_bdw_walker.sv
`timescale 1ns/1ps
module test_bdw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic        rx_dir = 1'b0;
    logic        active, mem_req, mem_we, mem_gnt, intr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, tx_byte, rx_byte;
    logic        tx_valid, tx_ready, rx_last, rx_valid, rx_ready;
    logic [3:0]  mode_flags;
    logic [7:0]  fill_mask;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bdw_walker i_bdw_walker (.*);

    // Memory model with variable grant latency
    logic [7:0] mem [0:1023];
    int lat = 0, lat_cnt = 0, gnt_cnt = 0, req_cnt = 0, intr_rise = 0;
    logic intr_d = 1'b0;
    logic [7:0] txq [0:31];
    int tx_n = 0;

    initial begin
        mem_gnt = 1'b0;
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        if (mem_gnt) begin
            mem_gnt <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt >= lat) begin
                mem_gnt <= 1'b1;
                lat_cnt <= 0;
                lat     <= (lat + 1) % 3;
                if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:0]];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
        if (mem_gnt) gnt_cnt <= gnt_cnt + 1;
        if (mem_req) req_cnt <= req_cnt + 1;
        intr_d <= intr;
        if (intr && !intr_d) intr_rise <= intr_rise + 1;
        if (tx_valid && tx_ready && tx_n < 32) begin
            txq[tx_n] <= tx_byte;
            tx_n <= tx_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_hdr(input int a, input logic [15:0] nx, input logic [15:0] sz,
                           input logic [15:0] ln, input logic [7:0] stv);
        mem[a]   = nx[15:8];  mem[a+1] = nx[7:0];
        mem[a+2] = sz[15:8];  mem[a+3] = sz[7:0];
        mem[a+4] = ln[15:8];  mem[a+5] = ln[7:0];
        mem[a+6] = 8'h5A;     mem[a+7] = stv;
    endtask

    task automatic pulse_start(input logic [15:0] a, input logic d);
        @(negedge clk);
        start = 1'b1; start_addr = a; rx_dir = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        @(negedge clk);
        while (active && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " walk ends"}, active, 1'b0);
    endtask

    // R1: reset values
    task automatic t_reset();
        @(negedge clk);
        chk("R1 active", active, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 intr", intr, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 mode_flags", mode_flags, 0);
        chk("R1 fill_mask", fill_mask, 8'hFF);
    endtask

    // R3: refused start addresses
    task automatic t_bad_start();
        int r0 = req_cnt;
        pulse_start(16'h0000, 1'b0);
        repeat (10) @(negedge clk);
        chk("R3 zero start active", active, 0);
        pulse_start(16'hFFF3, 1'b0);
        repeat (10) @(negedge clk);
        chk("R3 top start active", active, 0);
        chk("R3 no request", req_cnt - r0, 0);
    endtask

    // R2 R4 R5 R6 R7 R8 R11 R12: transmit chain data -> command -> data(bad link)
    task automatic t_tx_chain();
        int g0 = gnt_cnt;
        int i0 = intr_rise;
        int r1;
        logic [7:0] exp_b [0:4];
        put_hdr(16'h100, 16'h0140, 16'd16, 16'd3, 8'h00);
        mem[16'h108] = 8'hA1; mem[16'h109] = 8'hB2; mem[16'h10A] = 8'hC3;
        put_hdr(16'h140, 16'h0180, 16'd2, 16'd2, 8'h80);
        mem[16'h148] = 8'hFB; mem[16'h149] = 8'h3C;
        put_hdr(16'h180, 16'h0000, 16'd4, 16'd2, 8'h00);
        mem[16'h188] = 8'hD4; mem[16'h189] = 8'hE5;
        exp_b[0] = 8'hA1; exp_b[1] = 8'hB2; exp_b[2] = 8'hC3;
        exp_b[3] = 8'hD4; exp_b[4] = 8'hE5;
        tx_n = 0;
        pulse_start(16'h0100, 1'b0);
        chk("R2 started", active, 1);
        repeat (3) @(negedge clk);
        pulse_start(16'h0200, 1'b1);   // R12: ignored while busy
        for (int k = 0; k < 400 && active; k++) begin
            @(negedge clk);
            tx_ready = k[0] | k[2];
        end
        tx_ready = 1'b1;
        wait_idle("R7");
        repeat (4) @(negedge clk);
        chk("R4 byte count", tx_n, 5);
        for (int k = 0; k < 5; k++) chk("R4 R5 byte order", txq[k], exp_b[k]);
        chk("R5 status A done", mem[16'h107], 8'h01);
        chk("R6 status cmd done", mem[16'h147], 8'h81);
        chk("R7 status bad link", mem[16'h187], 8'h05);
        chk("R6 mode", mode_flags, 4'hB);
        chk("R6 fill", fill_mask, 8'h3C);
        chk("R8 intr strobes", intr_rise - i0, 3);
        chk("R11 grant count", gnt_cnt - g0, 31);
        chk("R11 spare byte untouched", mem[16'h106], 8'h5A);
        chk("R12 rx area untouched", mem[16'h207], 8'h00);
        r1 = req_cnt;
        repeat (10) @(negedge clk);
        chk("R7 quiet after error", req_cnt - r1, 0);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic last);
        int n = 0;
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_last = last;
        while (!rx_ready && n < 500) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    // R9 R10 R7 R8: receive into a capacity-limited buffer then a frame end
    task automatic t_rx_chain();
        int i0 = intr_rise;
        put_hdr(16'h200, 16'h0240, 16'd4, 16'hFFFF, 8'h00);
        put_hdr(16'h240, 16'hFFF0, 16'd8, 16'hFFFF, 8'h00);
        pulse_start(16'h0200, 1'b1);
        send_rx(8'h11, 1'b0); send_rx(8'h22, 1'b0);
        send_rx(8'h33, 1'b0); send_rx(8'h44, 1'b0);
        send_rx(8'h55, 1'b0); send_rx(8'h66, 1'b1);
        wait_idle("R9");
        chk("R10 byte0", mem[16'h208], 8'h11);
        chk("R10 byte3", mem[16'h20B], 8'h44);
        chk("R10 len hi", mem[16'h204], 8'h00);
        chk("R10 len lo", mem[16'h205], 8'h04);
        chk("R10 status", mem[16'h207], 8'h01);
        chk("R10 no overrun", mem[16'h20C], 8'h00);
        chk("R9 byte0", mem[16'h248], 8'h55);
        chk("R9 byte1", mem[16'h249], 8'h66);
        chk("R9 len hi", mem[16'h244], 8'h00);
        chk("R9 len lo", mem[16'h245], 8'h02);
        chk("R9 R7 status", mem[16'h247], 8'h07);
        chk("R8 rx intr strobes", intr_rise - i0, 2);
    endtask

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
        tx_ready = 1'b0; rx_valid = 1'b0; rx_byte = '0; rx_last = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bad_start();
        t_tx_chain();
        t_rx_chain();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule